// File: doc/BRIEF.md
# Delay Tap Tuning Sequencer

This block calibrates the sampling delay of a memory-card host interface. A sweep steps the delay control through all 32 ratio settings. At each setting it asks an external command engine for one tuning-block transfer and records whether that transfer passed. When the sweep is finished, the block searches the recorded results for the longest run of passing settings. It then programs the centre of that run as the operating delay.

A mode input states whether the delay line spans one full clock period. In that mode the settings form a ring, so a passing run may continue from setting 31 into setting 0. Outside that mode the settings form a line with two ends. A sweep starts on a software request. It also starts on its own when the data lines report an error while the interface is operating, or when a programmable retune interval runs out.

Top module: `tap_tune_seq`

## Requirements
- R1: After reset, busy, done, cmdReq, tuneFail, passMap, selTap and delayTap are all zero.
- R2: A sweep issues exactly 32 requests, one per tap, in increasing tap order 0 to 31. While a request is raised, delayTap equals the tap under test and stays constant. cmdReq is low for at least one cycle after each response.
- R3: cmdIdx is 19 when cmdSel was 0 at sweep start, and 21 when cmdSel was 1.
- R4: passMap bit i holds cmdPass from the response for tap i. A request with no cmdAck is dropped after exactly RSP_TIMEOUT cycles of cmdReq, and that tap is recorded as 0.
- R5: With dllMode 0 at sweep start, the winner is the longest run of consecutive 1 bits in passMap that does not wrap. Equal lengths resolve to the run with the lowest first tap. selTap becomes start + floor((length-1)/2).
- R6: With dllMode 1 at sweep start, tap 31 neighbours tap 0. A run may wrap past 31, its start is its first tap in forward order, and selTap is the midpoint computed modulo 32.
- R7: When every tap passes, selTap becomes 16 with dllMode 1 and 15 with dllMode 0.
- R8: When no tap passes, tuneFail becomes 1 and selTap keeps its previous value. The next sweep that finds a passing tap clears tuneFail.
- R9: done is a one-cycle pulse, and busy falls in the same cycle. selTap and tuneFail change only in a done cycle. done comes 34 cycles (dllMode 0) or 66 cycles (dllMode 1) after the cycle that records the last tap.
- R10: A one-cycle dataErr pulse while idle starts a full sweep. dataErr and tuneStart are ignored while busy.
- R11: With retunePeriod P other than 0, a sweep starts on its own so that cmdReq rises P cycles after the previous done. With P equal to 0 no automatic sweep starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tuneStart | input | 1 | Software request for a sweep |
| dataErr | input | 1 | Data-line error status; starts a sweep when idle |
| dllMode | input | 1 | 1: taps span one clock period (ring search); sampled at sweep start |
| cmdSel | input | 1 | Tuning command choice (0: 19, 1: 21); sampled at sweep start |
| retunePeriod | input | TMR_W | Idle cycles before an automatic retune; 0 disables |
| cmdReq | output | 1 | Request to the command engine for one tuning transfer |
| cmdIdx | output | 6 | Command index to issue |
| cmdAck | input | 1 | One-cycle response from the command engine |
| cmdPass | input | 1 | Pass flag qualified by cmdAck |
| delayTap | output | 5 | Delay setting driven to the delay line |
| selTap | output | 5 | Tap chosen by the last successful sweep |
| passMap | output | 32 | Pass/fail result of the last sweep, bit i for tap i |
| busy | output | 1 | Sweep or search in progress |
| done | output | 1 | One-cycle pulse when a sweep finishes |
| tuneFail | output | 1 | Last sweep found no passing tap |

## Verification
The window search is driven with pass patterns that separate one rule from another. Two runs of different length check that length is what counts. Two equal runs check the lowest-start tie rule. One pattern has runs at both ends plus a longer run that wraps, and it is swept in both modes so that the ring search and the line search must give different midpoints. The set also includes an all-pass map in each mode, an all-fail map, and a map where a timed-out response cuts a long run in two. Starts by software request, by data error and by the retune timer are compared for exact start cycles, and error pulses injected during a sweep must not disturb it.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
  localparam int TAP_W    = 5;
  localparam int NUM_TAPS = 1 << TAP_W;
  localparam int LEN_W    = TAP_W + 1;
  localparam int CMD_W    = 6;
  localparam logic [CMD_W-1:0] CMD_TUNE_A = CMD_W'(19);
  localparam logic [CMD_W-1:0] CMD_TUNE_B = CMD_W'(21);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETTLE,
    ST_SCAN,
    ST_FINISH
  } seq_state_e;

  typedef struct packed {
    logic sweepInit;
    logic record;
    logic recPass;
    logic scanInit;
    logic scanStep;
    logic commit;
  } seq_strobe_t;
endpackage

// File: rtl/tap_tune_dp.sv
module tap_tune_dp
  import tap_tune_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         stb,
  input  logic                dllMode,
  input  logic                cmdSel,
  output logic [TAP_W-1:0]    curTap,
  output logic                lastTap,
  output logic                scanLast,
  output logic [NUM_TAPS-1:0] passMap,
  output logic [CMD_W-1:0]    cmdIdx,
  output logic [TAP_W-1:0]    selTap,
  output logic                tuneFail,
  output logic                done
);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(NUM_TAPS);
  localparam logic [LEN_W-1:0] END_LINE = LEN_W'(NUM_TAPS - 1);
  localparam logic [LEN_W-1:0] END_RING = {LEN_W{1'b1}};
  localparam logic [TAP_W-1:0] RING_MID = TAP_W'(NUM_TAPS / 2);

  logic             wrapLat;
  logic [LEN_W-1:0] scanIdx;
  logic [TAP_W-1:0] runStart, bestStart;
  logic [LEN_W-1:0] runLen, bestLen;

  logic             scanBit, runFresh, allPass;
  logic [LEN_W-1:0] nextLen, scanEnd;
  logic [TAP_W-1:0] nextStart, halfLen, midTap;

  assign lastTap  = (curTap == {TAP_W{1'b1}});
  assign scanBit  = passMap[scanIdx[TAP_W-1:0]];
  assign runFresh = (runLen == '0);
  assign nextLen  = runFresh ? LEN_W'(1) : ((runLen == LEN_MAX) ? runLen : runLen + LEN_W'(1));
  assign nextStart = runFresh ? scanIdx[TAP_W-1:0] : runStart;
  assign scanEnd  = wrapLat ? END_RING : END_LINE;
  assign scanLast = (scanIdx == scanEnd);
  assign allPass  = &passMap;
  assign halfLen  = TAP_W'((bestLen - LEN_W'(1)) >> 1);
  assign midTap   = bestStart + halfLen;

  // Per-tap result bits
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rstN || stb.sweepInit) passMap[g] <= 1'b0;
      else if (stb.record && curTap == TAP_W'(g)) passMap[g] <= stb.recPass;
    end
  end

  // Sweep position and latched sweep options
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTap  <= '0;
      wrapLat <= 1'b0;
      cmdIdx  <= CMD_TUNE_A;
    end else if (stb.sweepInit) begin
      curTap  <= '0;
      wrapLat <= dllMode;
      cmdIdx  <= cmdSel ? CMD_TUNE_B : CMD_TUNE_A;
    end else if (stb.record) begin
      curTap  <= curTap + TAP_W'(1);
    end
  end

  // Longest-run search, one tap per cycle; ring mode walks the map twice
  always_ff @(posedge clk) begin
    if (!rstN || stb.scanInit) begin
      scanIdx   <= '0;
      runStart  <= '0;
      runLen    <= '0;
      bestStart <= '0;
      bestLen   <= '0;
    end else if (stb.scanStep) begin
      scanIdx <= scanIdx + LEN_W'(1);
      if (scanBit) begin
        runLen   <= nextLen;
        runStart <= nextStart;
        if (nextLen > bestLen) begin
          bestLen   <= nextLen;
          bestStart <= nextStart;
        end
      end else begin
        runLen <= '0;
      end
    end
  end

  // Result commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selTap   <= '0;
      tuneFail <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= stb.commit;
      if (stb.commit) begin
        if (bestLen == '0) begin
          tuneFail <= 1'b1;
        end else begin
          tuneFail <= 1'b0;
          selTap   <= (wrapLat && allPass) ? RING_MID : midTap;
        end
      end
    end
  end
endmodule

// File: rtl/tap_tune_ctrl.sv
module tap_tune_ctrl
  import tap_tune_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64,
  parameter int TMR_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tuneStart,
  input  logic             dataErr,
  input  logic [TMR_W-1:0] retunePeriod,
  input  logic             cmdAck,
  input  logic             cmdPass,
  input  logic             lastTap,
  input  logic             scanLast,
  output seq_strobe_t      stb,
  output logic             cmdReq,
  output logic             busy,
  output logic             sweepPhase
);
  localparam int TO_W = $clog2(RSP_TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(RSP_TIMEOUT - 1);

  seq_state_e       state, nextState;
  logic [TO_W-1:0]  toCnt;
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrArmed, tmrExpire, trigger, rspTimeout;

  assign tmrArmed   = (retunePeriod != '0);
  assign tmrExpire  = (state == ST_IDLE) && tmrArmed && (tmrCnt >= retunePeriod - TMR_W'(1));
  assign trigger    = tuneStart || dataErr || tmrExpire;
  assign rspTimeout = (toCnt == TO_LAST);

  assign cmdReq     = (state == ST_REQ);
  assign busy       = (state != ST_IDLE);
  assign sweepPhase = (state == ST_REQ) || (state == ST_SETTLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (trigger) begin
          stb.sweepInit = 1'b1;
          nextState     = ST_REQ;
        end
      end
      ST_REQ: begin
        if (cmdAck || rspTimeout) begin
          stb.record  = 1'b1;
          stb.recPass = cmdAck && cmdPass;
          if (lastTap) begin
            stb.scanInit = 1'b1;
            nextState    = ST_SCAN;
          end else begin
            nextState = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: nextState = ST_REQ;
      ST_SCAN: begin
        stb.scanStep = 1'b1;
        if (scanLast) nextState = ST_FINISH;
      end
      ST_FINISH: begin
        stb.commit = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      toCnt  <= '0;
      tmrCnt <= '0;
    end else begin
      state  <= nextState;
      toCnt  <= (state == ST_REQ && nextState == ST_REQ) ? toCnt + TO_W'(1) : '0;
      tmrCnt <= (state == ST_IDLE && tmrArmed && !trigger) ? tmrCnt + TMR_W'(1) : '0;
    end
  end
endmodule

// File: rtl/tap_tune_seq.sv
module tap_tune_seq
  import tap_tune_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64,
  parameter int TMR_W       = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tuneStart,
  input  logic                dataErr,
  input  logic                dllMode,
  input  logic                cmdSel,
  input  logic [TMR_W-1:0]    retunePeriod,
  output logic                cmdReq,
  output logic [CMD_W-1:0]    cmdIdx,
  input  logic                cmdAck,
  input  logic                cmdPass,
  output logic [TAP_W-1:0]    delayTap,
  output logic [TAP_W-1:0]    selTap,
  output logic [NUM_TAPS-1:0] passMap,
  output logic                busy,
  output logic                done,
  output logic                tuneFail
);
  seq_strobe_t      stb;
  logic [TAP_W-1:0] curTap;
  logic             lastTap, scanLast, sweepPhase;

  tap_tune_ctrl #(
    .RSP_TIMEOUT(RSP_TIMEOUT),
    .TMR_W      (TMR_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .tuneStart   (tuneStart),
    .dataErr     (dataErr),
    .retunePeriod(retunePeriod),
    .cmdAck      (cmdAck),
    .cmdPass     (cmdPass),
    .lastTap     (lastTap),
    .scanLast    (scanLast),
    .stb         (stb),
    .cmdReq      (cmdReq),
    .busy        (busy),
    .sweepPhase  (sweepPhase)
  );

  tap_tune_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .dllMode (dllMode),
    .cmdSel  (cmdSel),
    .curTap  (curTap),
    .lastTap (lastTap),
    .scanLast(scanLast),
    .passMap (passMap),
    .cmdIdx  (cmdIdx),
    .selTap  (selTap),
    .tuneFail(tuneFail),
    .done    (done)
  );

  assign delayTap = sweepPhase ? curTap : selTap;
endmodule

// File: rtl/tap_tune_chk.sv
module tap_tune_chk
  import tap_tune_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdReq,
  input logic                cmdAck,
  input logic [CMD_W-1:0]    cmdIdx,
  input logic [TAP_W-1:0]    delayTap,
  input logic [TAP_W-1:0]    selTap,
  input logic [NUM_TAPS-1:0] passMap,
  input logic                busy,
  input logic                done,
  input logic                tuneFail
);
  int reqRun;

  always_ff @(posedge clk) begin
    if (!rstN || !cmdReq) reqRun <= 0;
    else reqRun <= reqRun + 1;
  end

  p_req_in_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> busy);
  p_req_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdAck) |=> !cmdReq);
  p_tap_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && $past(cmdReq)) |-> $stable(delayTap));
  p_cmd_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> (cmdIdx == CMD_W'(19) || cmdIdx == CMD_W'(21)));
  p_timeout_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> (reqRun < RSP_TIMEOUT));
  p_fail_keeps_tap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && tuneFail) |-> ($stable(selTap) && passMap == '0));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_sel_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(selTap) && $stable(tuneFail)));
endmodule

bind tap_tune_seq tap_tune_chk #(.RSP_TIMEOUT(RSP_TIMEOUT)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdReq  (cmdReq),
  .cmdAck  (cmdAck),
  .cmdIdx  (cmdIdx),
  .delayTap(delayTap),
  .selTap  (selTap),
  .passMap (passMap),
  .busy    (busy),
  .done    (done),
  .tuneFail(tuneFail)
);

// File: tb/tap_tune_seq_tb_top.sv
module tap_tune_seq_tb_top;
  localparam int TO  = 8;
  localparam int TMW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tuneStart = 1'b0, dataErr = 1'b0, dllMode = 1'b0, cmdSel = 1'b0;
  logic [TMW-1:0] retunePeriod = '0;
  logic        cmdReq, cmdAck = 1'b0, cmdPass = 1'b0;
  logic [5:0]  cmdIdx;
  logic [4:0]  delayTap, selTap;
  logic [31:0] passMap;
  logic        busy, done, tuneFail;

  int total = 0;
  int bad = 0;
  int expSel = 0;
  bit expFail = 1'b0;
  bit monOn = 1'b0;
  logic [4:0] prevSel;
  logic       prevFail;

  always #5 clk = ~clk;

  tap_tune_seq #(.RSP_TIMEOUT(TO), .TMR_W(TMW)) dut_i (
    .clk(clk), .rstN(rstN), .tuneStart(tuneStart), .dataErr(dataErr),
    .dllMode(dllMode), .cmdSel(cmdSel), .retunePeriod(retunePeriod),
    .cmdReq(cmdReq), .cmdIdx(cmdIdx), .cmdAck(cmdAck), .cmdPass(cmdPass),
    .delayTap(delayTap), .selTap(selTap), .passMap(passMap),
    .busy(busy), .done(done), .tuneFail(tuneFail)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] span(input int lo, input int hi);
    logic [31:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Reference: brute-force longest window, ties to lowest start
  function automatic void refPick(input logic [31:0] m, input bit wrap, inout int sel, output bit fail);
    int bestL = 0;
    int bestS = 0;
    fail = 1'b0;
    if (m == '0) begin fail = 1'b1; return; end
    if (wrap && m == 32'hFFFF_FFFF) begin sel = 16; return; end
    for (int s = 0; s < 32; s++) begin
      bit isStart;
      int len;
      isStart = m[s] && (wrap ? !m[(s + 31) % 32] : (s == 0 || !m[(s + 31) % 32]));
      if (isStart) begin
        len = 0;
        while (len < 32 && m[(s + len) % 32] && (wrap || s + len < 32)) len++;
        if (len > bestL) begin bestL = len; bestS = s; end
      end
    end
    sel = (bestS + (bestL - 1) / 2) % 32;
  endfunction

  // Per-clock comparison of the committed outputs against the reference state
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (!done) begin
        chk(selTap == prevSel, "R9 selTap held", selTap, prevSel);
        chk(tuneFail == prevFail, "R9 tuneFail held", tuneFail, prevFail);
      end
    end
    prevSel  = selTap;
    prevFail = tuneFail;
  end

  task automatic waitReq(output int steps);
    steps = 0;
    while (!cmdReq && steps < 400) begin
      @(negedge clk);
      steps++;
    end
  endtask

  // trig: 0 software start, 1 data error, 2 timer (expects request after period)
  task automatic runSweep(input logic [31:0] m, input logic [31:0] toMask, input bit wrap,
                          input bit sel, input int trig, input bit noise, input string tag);
    int steps;
    int k;
    int hi;
    int n;
    int per;
    bit f;
    logic [31:0] expMap;
    dllMode = wrap;
    cmdSel  = sel;
    if (trig == 0) begin
      tuneStart = 1'b1; @(negedge clk); tuneStart = 1'b0;
    end else if (trig == 1) begin
      dataErr = 1'b1; @(negedge clk); dataErr = 1'b0;
    end
    per = int'(retunePeriod);
    waitReq(steps);
    if (trig == 2) begin
      chk(steps == per, "R11 timer start", steps, per);
      retunePeriod = '0;
    end
    chk(cmdReq == 1'b1, "R10 sweep started", cmdReq, 1);
    for (int t = 0; t < 32; t++) begin
      if (t > 0) waitReq(steps);
      chk(delayTap == 5'(t), "R2 tap order", delayTap, t);
      chk(cmdIdx == (sel ? 6'd21 : 6'd19), "R3 command index", cmdIdx, sel ? 21 : 19);
      if (toMask[t]) begin
        hi = 1;
        forever begin
          @(negedge clk);
          if (cmdReq && hi < 100) hi++;
          else break;
        end
        chk(hi == TO, "R4 timeout length", hi, TO);
      end else begin
        for (int d = 0; d < t % 3; d++) begin
          @(negedge clk);
          chk(cmdReq == 1'b1, "R2 request held", cmdReq, 1);
        end
        cmdAck = 1'b1;
        cmdPass = m[t];
        if (noise && t == 5) begin tuneStart = 1'b1; dataErr = 1'b1; end
        @(negedge clk);
        cmdAck = 1'b0; cmdPass = 1'b0; tuneStart = 1'b0; dataErr = 1'b0;
        chk(cmdReq == 1'b0, "R2 gap after response", cmdReq, 0);
      end
    end
    n = wrap ? 64 : 32;
    k = 1;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    chk(k == n + 2, "R9 done latency", k, n + 2);
    chk(busy == 1'b0, "R9 busy falls with done", busy, 0);
    expMap = m & ~toMask;
    chk(passMap == expMap, "R4 pass map", passMap, expMap);
    refPick(expMap, wrap, expSel, f);
    expFail = f;
    chk(tuneFail == expFail, {tag, " tuneFail"}, tuneFail, expFail);
    chk(selTap == 5'(expSel), {tag, " selTap"}, selTap, expSel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int steps;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && cmdReq == 0, "R1 control idle", {busy, done, cmdReq}, 0);
    chk(passMap == 0 && tuneFail == 0, "R1 results clear", passMap, 0);
    chk(selTap == 0 && delayTap == 0, "R1 taps zero", {selTap, delayTap}, 0);
    monOn = 1'b1;

    // R5 two runs of different length, line mode
    runSweep(span(3, 7) | span(12, 20), '0, 1'b0, 1'b0, 0, 1'b0, "R5 longer run");
    // R5 equal runs: lowest start wins
    runSweep(span(2, 5) | span(20, 23), '0, 1'b0, 1'b1, 0, 1'b0, "R5 tie");
    // R5/R6 same map in both modes: ends joined only in ring mode
    runSweep(span(0, 6) | span(12, 16) | span(29, 31), '0, 1'b0, 1'b0, 0, 1'b0, "R5 line ends");
    runSweep(span(0, 6) | span(12, 16) | span(29, 31), '0, 1'b1, 1'b1, 0, 1'b0, "R6 ring wrap");
    // R7 all pass in each mode
    runSweep(32'hFFFF_FFFF, '0, 1'b1, 1'b0, 0, 1'b0, "R7 ring all pass");
    runSweep(32'hFFFF_FFFF, '0, 1'b0, 1'b0, 0, 1'b0, "R7 line all pass");
    // R4 a timed-out tap splits a long run
    runSweep(32'hFFFF_FFFF, 32'h0000_0400, 1'b0, 1'b0, 0, 1'b0, "R4 timeout split");
    // R8 nothing passes: flag set, tap kept
    runSweep(32'h0000_0000, 32'h8000_0003, 1'b0, 1'b0, 0, 1'b0, "R8 no pass");
    chk(selTap == 5'd21, "R8 previous tap kept", selTap, 21);
    // R8 recovery and R10 data-error start with noise during sweep
    runSweep(span(8, 12), '0, 1'b1, 1'b0, 1, 1'b1, "R8 recover");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(cmdReq == 1'b0 && busy == 1'b0, "R10 noise while busy ignored", busy, 0);
    end
    // R11 timer start exactly P cycles after done
    runSweep(span(1, 4), '0, 1'b0, 1'b0, 0, 1'b0, "R11 before timer");
    retunePeriod = 16'd20;
    runSweep(span(24, 30), '0, 1'b0, 1'b1, 2, 1'b0, "R11 timer sweep");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(cmdReq == 1'b0, "R11 disabled timer idle", cmdReq, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule